// File: doc/BRIEF.md
# Configurable MCU I/O Port Controller

This block sits between a microcontroller's parallel register bus and an 8-bit group of pins. Software sets each pin on its own through three configuration registers. The source register picks what the pin carries: the microcontroller's output data or a bit of an internal address bus. The direction register decides whether the pin drives. A hardware output-enable term from surrounding logic can also force the pin to drive, whatever the software setting. The drive-style register makes some pins open-drain. On the other pins it only raises a fast-slew flag for the pad ring.

An input register samples the pin levels on every clock, and software can read it whatever the pin directions are. A build parameter selects a reduced variant. This variant has no source register and only three direction bits. Two parameter vectors mark which pins can be open-drain and which pins have a slew-rate control.

Top module: `cfg_io_port`

## Requirements
- R1: A synchronous active-low reset clears the source, direction and drive-style registers to 00h. With `pt_oe` low, `pad_oe` is then 00h and `fast_slew` is 00h.
- R2: A register is written on the rising clock edge where `bus_sel` and `bus_wr` are both 1. The offsets are source 3'h2, direction 3'h4 and drive style 3'h6. A read at the same offset returns the written value. When `bus_sel` or `bus_wr` is 0, no register changes.
- R3: Source bit i = 0 puts `mcu_dout[i]` on the pin. A 1 puts `addr_bus[i]` on the pin.
- R4: On a push-pull pin, `pad_oe[i]` is 1 exactly when direction bit i or `pt_oe[i]` is 1. When both are 0, the pin is an input.
- R5: A pin is open-drain when its bit in `OD_PINS` is 1 and its drive-style bit is 1. Such a pin has `pad_out` = 0. It enables its driver only when it is enabled for output (R4) and its source value is 0, so it pulls low for a 0 and releases for a 1.
- R6: `fast_slew[i]` equals drive-style bit i on pins marked in `SLEW_PINS` and is 0 on all other pins. On a pin that cannot be open-drain, the drive-style bit has no effect on `pad_out` or `pad_oe`.
- R7: A read at offset 3'h0 returns `pin_in` as sampled at the previous rising edge, for every pin direction.
- R8: With `FULL_PORT` = 0, the direction register keeps only bits 2:0. Writes to the upper bits are dropped and those bits read as 0. The source register is absent: it reads as 0 and every pin carries `mcu_dout`.
- R9: `bus_rdata` is 00h when `bus_sel` is 0, and also at the unmapped odd offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Chip select for the register window |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected offset |
| mcu_dout | input | 8 | Microcontroller output data per pin |
| addr_bus | input | 8 | Internal address bits for address-out pins |
| pt_oe | input | 8 | Hardware output-enable term per pin |
| pin_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Pad driver enable |
| fast_slew | output | 8 | Fast slew-rate request per pin |

## Verification
A corrupted configuration bit shows at the pads in the first cycle after the write edge. The wrong pin then drives, or carries the wrong source, or an open-drain pin actively drives high. The bench therefore compares `pad_out`, `pad_oe` and `fast_slew` with a register model in every cycle, against a random mix of mcu data, address bits and output-enable terms. A stuck or mis-decoded register that does not change the pads in a given cycle still shows up one cycle later, through the read-back at a random offset. The input register is checked one edge after each change on the pins, and a reduced-variant instance runs beside the full one on the same bus.

// File: rtl/cfg_io_port_pkg.sv
`timescale 1ns/1ps
// Shared constants for the configurable I/O port: bus offset width and register offsets.
package cfg_io_port_pkg;
    localparam int OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_DIN  = 3'h0;
    localparam logic [OFS_W-1:0] OFS_SRC  = 3'h2;
    localparam logic [OFS_W-1:0] OFS_DIR  = 3'h4;
    localparam logic [OFS_W-1:0] OFS_DRV  = 3'h6;
endpackage

// File: rtl/cfg_io_din_sampler.sv
`timescale 1ns/1ps
// Input sampler: registers the pad levels on every clock edge.
// Assumes pin_in is already synchronous or synchronised upstream. It has no reset
// because the value is overwritten on every edge.
module cfg_io_din_sampler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] din_q
);
    // Capture the pad levels each cycle.
    always_ff @(posedge clk) begin
        din_q <= pin_in;
    end
endmodule

// File: rtl/cfg_io_regs.sv
`timescale 1ns/1ps
// Configuration register file: source, direction and drive-style registers.
// It also holds the read multiplexer. Writes happen on an edge with sel and wr both high.
// Reads are combinational. Assumes the bus holds its offset steady around the edge.
module cfg_io_regs
    import cfg_io_port_pkg::*;
#(
    parameter int            W         = 8,
    parameter bit            FULL_PORT = 1'b1,
    parameter logic [W-1:0]  DIR_MASK  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [OFS_W-1:0] addr,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     rdata,
    output logic [W-1:0]     src_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     drv_q
);
    logic wr_hit;
    assign wr_hit = sel & wr;

    // Direction register, keeping only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_hit && addr == OFS_DIR)
            dir_q <= wdata & DIR_MASK;
    end

    // Drive-style register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drv_q <= '0;
        else if (wr_hit && addr == OFS_DRV)
            drv_q <= wdata;
    end

    generate
        if (FULL_PORT) begin : g_src
            // Source-select register, present only on the full port.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    src_q <= '0;
                else if (wr_hit && addr == OFS_SRC)
                    src_q <= wdata;
            end
        end else begin : g_nosrc
            assign src_q = '0;
        end
    endgenerate

    // Read multiplexer. Unselected or unmapped offsets read as zero.
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (addr)
                OFS_DIN: rdata = din;
                OFS_SRC: rdata = src_q;
                OFS_DIR: rdata = dir_q;
                OFS_DRV: rdata = drv_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_io_pin_slice.sv
`timescale 1ns/1ps
// One pin's output path. It selects the output source, merges the software and
// hardware enables, and applies open-drain qualification when the pin supports it.
// The capability bits are fixed at build time.
module cfg_io_pin_slice #(
    parameter bit OD_OK   = 1'b0,
    parameter bit SLEW_OK = 1'b0
) (
    input  logic src_sel,
    input  logic dir_bit,
    input  logic drv_bit,
    input  logic hw_oe,
    input  logic mcu_bit,
    input  logic addr_bit,
    output logic pad_out,
    output logic pad_oe,
    output logic slew_fast
);
    logic value;
    logic want_drive;
    logic od_mode;

    // Pick the data source and combine the enables.
    always_comb begin
        value      = src_sel ? addr_bit : mcu_bit;
        want_drive = dir_bit | hw_oe;
    end

    generate
        if (OD_OK) begin : g_od
            assign od_mode = drv_bit;
        end else begin : g_pp
            assign od_mode = 1'b0;
        end
        if (SLEW_OK) begin : g_slew
            assign slew_fast = drv_bit;
        end else begin : g_noslew
            assign slew_fast = 1'b0;
        end
    endgenerate

    // Open drain pulls low only; push-pull drives the value directly.
    always_comb begin
        if (od_mode) begin
            pad_out = 1'b0;
            pad_oe  = want_drive & ~value;
        end else begin
            pad_out = value;
            pad_oe  = want_drive;
        end
    end
endmodule

// File: rtl/cfg_io_port.sv
`timescale 1ns/1ps
// Configurable I/O port top: register file, input sampler and one slice per pin.
// FULL_PORT=0 builds the reduced variant, with no source register and RED_PINS direction bits.
// OD_PINS and SLEW_PINS mark which pins have each capability.
module cfg_io_port
    import cfg_io_port_pkg::*;
#(
    parameter int                  PORT_W    = 8,
    parameter bit                  FULL_PORT = 1'b1,
    parameter int                  RED_PINS  = 3,
    parameter logic [PORT_W-1:0]   OD_PINS   = 8'h0F,
    parameter logic [PORT_W-1:0]   SLEW_PINS = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] mcu_dout,
    input  logic [PORT_W-1:0] addr_bus,
    input  logic [PORT_W-1:0] pt_oe,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] fast_slew
);
    localparam logic [PORT_W-1:0] RED_MASK = PORT_W'((1 << RED_PINS) - 1);
    localparam logic [PORT_W-1:0] DIR_MASK = FULL_PORT ? {PORT_W{1'b1}} : RED_MASK;

    logic [PORT_W-1:0] din_q;
    logic [PORT_W-1:0] src_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] drv_q;

    cfg_io_din_sampler #(.W(PORT_W)) sampler_i (
        .clk    (clk),
        .pin_in (pin_in),
        .din_q  (din_q)
    );

    cfg_io_regs #(
        .W         (PORT_W),
        .FULL_PORT (FULL_PORT),
        .DIR_MASK  (DIR_MASK)
    ) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .din   (din_q),
        .rdata (bus_rdata),
        .src_q (src_q),
        .dir_q (dir_q),
        .drv_q (drv_q)
    );

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            cfg_io_pin_slice #(
                .OD_OK   (OD_PINS[i]),
                .SLEW_OK (SLEW_PINS[i])
            ) slice_i (
                .src_sel   (src_q[i]),
                .dir_bit   (dir_q[i]),
                .drv_bit   (drv_q[i]),
                .hw_oe     (pt_oe[i]),
                .mcu_bit   (mcu_dout[i]),
                .addr_bit  (addr_bus[i]),
                .pad_out   (pad_out[i]),
                .pad_oe    (pad_oe[i]),
                .slew_fast (fast_slew[i])
            );
        end
    endgenerate
endmodule

// File: rtl/cfg_io_port_chk.sv
`timescale 1ns/1ps
// Assertion checker for cfg_io_port, bound to every instance of it.
// It checks the reset state, the register writes, the enable merge, open-drain safety,
// slew gating, the input read path and the reduced-variant masking.
module cfg_io_port_chk
    import cfg_io_port_pkg::*;
#(
    parameter int              W        = 8,
    parameter logic [W-1:0]    DIR_MASK = '1,
    parameter logic [W-1:0]    OD_M     = '0,
    parameter logic [W-1:0]    SLEW_M   = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [OFS_W-1:0] bus_addr,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     bus_rdata,
    input logic [W-1:0]     pt_oe,
    input logic [W-1:0]     pin_in,
    input logic [W-1:0]     pad_out,
    input logic [W-1:0]     pad_oe,
    input logic [W-1:0]     fast_slew,
    input logic [W-1:0]     src_q,
    input logic [W-1:0]     dir_q,
    input logic [W-1:0]     drv_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (src_q == '0 && dir_q == '0 && drv_q == '0)); // R1

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> (dir_q == ($past(bus_wdata) & DIR_MASK))); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(src_q) && $stable(dir_q) && $stable(drv_q))); // R2

    AST_IDLE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q | pt_oe) == '0) |-> (pad_oe == '0)); // R4

    AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (((dir_q | pt_oe) & ~(drv_q & OD_M) & ~pad_oe) == '0)); // R4

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & drv_q & OD_M) == '0)); // R5

    AST_SLEW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((fast_slew & ~SLEW_M) == '0)); // R6

    AST_DIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == OFS_DIN) |-> (bus_rdata == $past(pin_in))); // R7

    AST_REDUCED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == OFS_DIR) |-> ((bus_rdata & ~DIR_MASK) == '0)); // R8

    AST_UNSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0)); // R9
endmodule

bind cfg_io_port cfg_io_port_chk #(
    .W        (PORT_W),
    .DIR_MASK (DIR_MASK),
    .OD_M     (OD_PINS),
    .SLEW_M   (SLEW_PINS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pt_oe     (pt_oe),
    .pin_in    (pin_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .fast_slew (fast_slew),
    .src_q     (src_q),
    .dir_q     (dir_q),
    .drv_q     (drv_q)
);

// File: tb/cfg_io_port_tb_top.sv
`timescale 1ns/1ps
// Bench: a full and a reduced instance share one bus. Random and directed stimulus
// is checked against a register model held in the bench.
module cfg_io_port_tb_top;
    localparam logic [7:0] OD_M   = 8'h0F;
    localparam logic [7:0] SLEW_M = 8'hF0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'h0;
    logic [7:0] bus_wdata = 8'h00, mcu_dout = 8'h00, addr_bus = 8'h00, pt_oe = 8'h00, pin_in = 8'h00;
    logic [7:0] rdata_f, out_f, oe_f, slew_f;
    logic [7:0] rdata_r, out_r, oe_r, slew_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_src, m_dir, m_drv;

    always #4 clk = ~clk;

    cfg_io_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_f), .mcu_dout(mcu_dout), .addr_bus(addr_bus),
        .pt_oe(pt_oe), .pin_in(pin_in), .pad_out(out_f), .pad_oe(oe_f), .fast_slew(slew_f)
    );

    cfg_io_port #(.FULL_PORT(1'b0)) dut_red_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_r), .mcu_dout(mcu_dout), .addr_bus(addr_bus),
        .pt_oe(pt_oe), .pin_in(pin_in), .pad_out(out_r), .pad_oe(oe_r), .fast_slew(slew_r)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] f_val(input logic [7:0] s);
        return (s & addr_bus) | (~s & mcu_dout);
    endfunction
    function automatic logic [7:0] f_oe(input logic [7:0] s, input logic [7:0] d, input logic [7:0] v);
        logic [7:0] od = v & OD_M;
        return (d | pt_oe) & ~(od & f_val(s));
    endfunction
    function automatic logic [7:0] f_out(input logic [7:0] s, input logic [7:0] v);
        return f_val(s) & ~(v & OD_M);
    endfunction
    function automatic logic [7:0] f_rd(input bit full, input logic [2:0] a, input logic [7:0] din);
        if (!bus_sel) return 8'h00;
        case (a)
            3'h0: return din;
            3'h2: return full ? m_src : 8'h00;
            3'h4: return full ? m_dir : (m_dir & 8'h07);
            3'h6: return m_drv;
            default: return 8'h00;
        endcase
    endfunction

    // Compare the pad outputs of both instances with the model.
    task automatic chk_pads(input string tag);
        chk({tag, " R3/R5 full pad_out"}, out_f, f_out(m_src, m_drv));
        chk({tag, " R4/R5 full pad_oe"}, oe_f, f_oe(m_src, m_dir, m_drv));
        chk({tag, " R6 full fast_slew"}, slew_f, m_drv & SLEW_M);
        chk({tag, " R8 reduced pad_out"}, out_r, f_out(8'h00, m_drv));
        chk({tag, " R8 reduced pad_oe"}, oe_r, f_oe(8'h00, m_dir & 8'h07, m_drv));
    endtask

    // One bus write at the next edge, then release the strobe.
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic s);
        @(negedge clk);
        bus_sel = s; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (s) begin
            if (a == 3'h2) m_src = d;
            if (a == 3'h4) m_dir = d;
            if (a == 3'h6) m_drv = d;
        end
    endtask

    task automatic bus_read_chk(input logic [2:0] a, input logic [7:0] din, input string tag);
        bus_sel = 1'b1; bus_addr = a;
        #1;
        chk({tag, " full read"}, rdata_f, f_rd(1'b1, a, din));
        chk({tag, " R8 reduced read"}, rdata_r, f_rd(1'b0, a, din));
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        m_src = 8'h00; m_dir = 8'h00; m_drv = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk("R1 reset pad_oe", oe_f, 8'h00);
        chk("R1 reset fast_slew", slew_f, 8'h00);
        bus_read_chk(3'h2, 8'h00, "R1 src reset");
        bus_read_chk(3'h4, 8'h00, "R1 dir reset");
        bus_read_chk(3'h6, 8'h00, "R1 drv reset");

        // R2: write without select must not land
        bus_write(3'h4, 8'hFF, 1'b0);
        bus_read_chk(3'h4, 8'h00, "R2 unselected write");
        // R2 / R8: direction write, reduced keeps bits 2:0 only
        bus_write(3'h4, 8'hFF, 1'b1);
        bus_read_chk(3'h4, 8'h00, "R2 dir write");
        // R3: address source on the upper nibble
        mcu_dout = 8'hA5; addr_bus = 8'h3C;
        bus_write(3'h2, 8'hF0, 1'b1);
        #1; chk_pads("R3 directed");
        // R5 / R6: all drive bits set
        bus_write(3'h6, 8'hFF, 1'b1);
        #1; chk_pads("R5 directed open-drain");
        chk("R6 directed slew", slew_f, 8'hF0);
        // R4: hardware enable alone makes pins drive
        bus_write(3'h4, 8'h00, 1'b1);
        bus_write(3'h6, 8'h00, 1'b1);
        pt_oe = 8'h99; #1;
        chk("R4 pt_oe only", oe_f, 8'h99);
        pt_oe = 8'h00; #1;
        chk("R4 idle input", oe_f, 8'h00);
        // R7: input read independent of direction
        pin_in = 8'h6E;
        @(negedge clk);
        bus_read_chk(3'h0, 8'h6E, "R7 din");
        // R9: unmapped offset
        bus_read_chk(3'h5, 8'h00, "R9 unmapped");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            logic [2:0] wa, ra;
            logic [7:0] pv;
            bit ws;
            wa = 3'($urandom_range(0, 7));
            ws = ($urandom_range(0, 3) != 0);
            pv = 8'($urandom);
            @(negedge clk);
            bus_sel = ws; bus_wr = 1'b1; bus_addr = wa; bus_wdata = 8'($urandom);
            mcu_dout = 8'($urandom); addr_bus = 8'($urandom); pt_oe = 8'($urandom) & 8'($urandom);
            pin_in = pv;
            @(negedge clk);
            bus_wr = 1'b0;
            if (ws) begin
                if (wa == 3'h2) m_src = bus_wdata;
                if (wa == 3'h4) m_dir = bus_wdata;
                if (wa == 3'h6) m_drv = bus_wdata;
            end
            ra = 3'($urandom_range(0, 7));
            bus_sel = ($urandom_range(0, 7) != 0); bus_addr = ra;
            #1;
            chk_pads("R2 random");
            chk("R7/R9 random full read", rdata_f, f_rd(1'b1, ra, pv));
            chk("R8/R9 random reduced read", rdata_r, f_rd(1'b0, ra, pv));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule